// File: doc/BRIEF.md
# SIMD Fixed-Point Multiply-Accumulate Unit

This unit multiplies signed fixed-point operands in one of two shapes: a single 32x32 multiply, or four independent 16x16 multiplies working in parallel on the lanes of the operand words. A product can be sent straight to the result port. It can also be folded into a small bank of four 32-bit accumulators. In single mode two accumulators pair up into one 64-bit accumulator. In quad mode each accumulator serves one lane.

Each accumulator has its own group of four sticky overflow flags, held in a separate flag register. A combined transfer-and-restart operation reads an accumulator out and loads a fresh product into it in the same cycle. In fractional mode each product is doubled. The single case of most-negative times most-negative is clamped to the largest positive value. When a result is narrowed to half width, integer mode keeps the low half and fractional mode keeps the high half. Operations issue every cycle through a two-stage pipeline. The accumulate stage reads the accumulator it writes, so back-to-back accumulations need no stall.

Top module: `simd_mac`

## Requirements
- R1: After reset, acc_o, ovf_o and res_o are all zero and res_vld_o is low.
- R2: The operation code on op_i is 0 or 7 for idle, 1 for MUL, 2 for MAC (accumulate), 3 for SET (load product), 4 for XFR (transfer and clear), 5 for XMAC (transfer and load product) and 6 for CLR. An operation sampled at clock edge k updates res_o, acc_o and ovf_o at edge k+1. res_vld_o is high for exactly that one cycle when the operation is MUL, XFR or XMAC.
- R3: In single mode (quad_i=0) only a_i[31:0] and b_i[31:0] are used, and MUL yields their signed product. With wide_i=1, res_o[63:0] holds the 64-bit product. With wide_i=0, res_o[31:0] holds the low half in integer mode (frac_i=0) or the high half in fractional mode. All higher bits of res_o are zero.
- R4: In quad mode (quad_i=1), lane i multiplies a_i[16i+15:16i] by b_i[16i+15:16i] as signed values. On MUL with wide_i=1, the 32-bit lane i result is placed at res_o[32i+31:32i]. With wide_i=0, the lane i half (low in integer mode, high in fractional mode) is placed at res_o[16i+15:16i], and res_o[127:64] is zero.
- R5: In fractional mode every product is shifted left by one bit. Most-negative times most-negative gives the largest positive value: 64'h7FFF_FFFF_FFFF_FFFF in single mode and 32'h7FFF_FFFF per lane.
- R6: Accumulator k occupies acc_o[32k+31:32k]. In single mode, pair_i=0 selects the 64-bit accumulator {acc1,acc0} and pair_i=1 selects {acc3,acc2}. MAC adds the 64-bit product (wrapping) and SET loads it. The other pair is left unchanged.
- R7: In quad mode, MAC adds the 32-bit product of lane i into accumulator i (wrapping) and SET loads it, for all four lanes at once.
- R8: Operations issued on consecutive cycles give the same accumulator contents as the same operations issued one at a time.
- R9: XFR outputs the selected accumulator (pair or all four) using the same width and half selection as R3 and R4. It then clears that accumulator and its overflow flag groups.
- R10: XMAC outputs the old accumulator value exactly as XFR does and, in the same cycle, loads the new product into that accumulator.
- R11: The flag group of accumulator k is ovf_o[4k+3:4k]. Bit 0 marks a positive wrap, bit 1 a negative wrap, bit 2 a clamped product and bit 3 a wrap while bit 0 or bit 1 was already set. In single mode the flags go to the upper accumulator of the pair. MAC only sets flags. SET, XMAC, XFR and CLR reset the flag groups of their targets, and SET and XMAC then record bit 2 for the new product.
- R12: CLR zeroes the targeted accumulators and their flags without touching res_o. MUL and idle leave acc_o and ovf_o unchanged.
- R13: res_o holds its value when the operation is anything other than MUL, XFR or XMAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| quad_i | input | 1 | 1 = four 16x16 lanes, 0 = one 32x32 multiply |
| wide_i | input | 1 | 1 = full-width result, 0 = half-width result |
| frac_i | input | 1 | 1 = fractional mode, 0 = integer mode |
| pair_i | input | 1 | Accumulator pair select in single mode |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| res_o | output | 128 | Product or transferred accumulator |
| res_vld_o | output | 1 | res_o was written this cycle |
| acc_o | output | 128 | Accumulator contents |
| ovf_o | output | 16 | Sticky overflow flag groups |

## Verification
The bench sweeps grids of edge operands through both multiply shapes in every width and fractional combination. A unit that forgot the clamp would return the most-negative value for the doubled minimum square, and one that swapped the halves would hand back the wrong 16 or 32 bits. Accumulation runs are chosen to wrap a 64-bit pair twice and each quad lane downward. A design that cleared flags on accumulate, filed them under the wrong accumulator or never raised the repeat bit is caught against the arithmetic model. Back-to-back streams that end in a transfer-and-restart expose any pipeline hazard between the accumulate stage and a read-out in the following cycle.

// File: rtl/simd_mac.sv
module simd_mac #(
  parameter int LW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_i,
  input  logic            quad_i,
  input  logic            wide_i,
  input  logic            frac_i,
  input  logic            pair_i,
  input  logic [4*LW-1:0] a_i,
  input  logic [4*LW-1:0] b_i,
  output logic [8*LW-1:0] res_o,
  output logic            res_vld_o,
  output logic [8*LW-1:0] acc_o,
  output logic [15:0]     ovf_o
);
  localparam int SW = 2 * LW;
  localparam int DW = 4 * LW;
  localparam int NL = 4;
  localparam int RW = NL * SW;
  localparam int FW = 4 * NL;
  localparam logic [2:0] OP_MUL  = 3'd1;
  localparam logic [2:0] OP_MAC  = 3'd2;
  localparam logic [2:0] OP_SET  = 3'd3;
  localparam logic [2:0] OP_XFR  = 3'd4;
  localparam logic [2:0] OP_XMAC = 3'd5;
  localparam logic [2:0] OP_CLR  = 3'd6;
  localparam logic [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};
  localparam logic [LW-1:0] LMIN = {1'b1, {(LW-1){1'b0}}};

  // stage 1: multiply
  logic signed [DW-1:0] s_full;
  logic [DW-1:0] s_prod;
  logic s_sat;
  assign s_full = $signed({{SW{a_i[SW-1]}}, a_i[SW-1:0]}) * $signed({{SW{b_i[SW-1]}}, b_i[SW-1:0]});
  assign s_sat  = frac_i && a_i[SW-1:0] == SMIN && b_i[SW-1:0] == SMIN;
  assign s_prod = s_sat ? {1'b0, {(DW-1){1'b1}}} : (frac_i ? {s_full[DW-2:0], 1'b0} : s_full);

  logic [RW-1:0] l_prod;
  logic [NL-1:0] l_sat;
  for (genvar gi = 0; gi < NL; gi++) begin : g_mul
    logic [LW-1:0] la, lb;
    logic signed [SW-1:0] lf;
    assign la = a_i[gi*LW +: LW];
    assign lb = b_i[gi*LW +: LW];
    assign lf = $signed({{LW{la[LW-1]}}, la}) * $signed({{LW{lb[LW-1]}}, lb});
    assign l_sat[gi] = frac_i && la == LMIN && lb == LMIN;
    assign l_prod[gi*SW +: SW] = l_sat[gi] ? {1'b0, {(SW-1){1'b1}}} : (frac_i ? {lf[SW-2:0], 1'b0} : lf);
  end

  logic [2:0] p_op;
  logic p_quad, p_wide, p_frac, p_pair, p_ssat;
  logic [NL-1:0] p_lsat;
  logic [DW-1:0] p_sp;
  logic [RW-1:0] p_lp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_op <= '0; p_quad <= 1'b0; p_wide <= 1'b0; p_frac <= 1'b0; p_pair <= 1'b0;
      p_ssat <= 1'b0; p_lsat <= '0; p_sp <= '0; p_lp <= '0;
    end else begin
      p_op <= op_i; p_quad <= quad_i; p_wide <= wide_i; p_frac <= frac_i; p_pair <= pair_i;
      p_ssat <= s_sat; p_lsat <= l_sat; p_sp <= s_prod; p_lp <= l_prod;
    end
  end

  // stage 2: accumulate / transfer
  logic [RW-1:0] acc_q, acc_d, res_q, res_d;
  logic [FW-1:0] ovf_q, ovf_d;
  logic vld_q, vld_d;
  logic mac_op, new_op, clr_op, out_op;
  assign mac_op = p_op == OP_MAC;
  assign new_op = p_op == OP_SET || p_op == OP_XMAC;
  assign clr_op = p_op == OP_XFR || p_op == OP_CLR;
  assign out_op = p_op == OP_MUL || p_op == OP_XFR || p_op == OP_XMAC;

  logic [DW-1:0] pv, psum;
  logic p_pos, p_neg;
  assign pv    = p_pair ? acc_q[RW-1:DW] : acc_q[DW-1:0];
  assign psum  = pv + p_sp;
  assign p_pos = !pv[DW-1] && !p_sp[DW-1] && psum[DW-1];
  assign p_neg = pv[DW-1] && p_sp[DW-1] && !psum[DW-1];

  logic [RW-1:0] l_sum;
  logic [NL-1:0] l_pos, l_neg;
  logic [DW-1:0] acc_nar, lp_nar;
  for (genvar gk = 0; gk < NL; gk++) begin : g_lane
    logic [SW-1:0] ov, pp, sm;
    assign ov = acc_q[gk*SW +: SW];
    assign pp = p_lp[gk*SW +: SW];
    assign sm = ov + pp;
    assign l_sum[gk*SW +: SW] = sm;
    assign l_pos[gk] = !ov[SW-1] && !pp[SW-1] && sm[SW-1];
    assign l_neg[gk] = ov[SW-1] && pp[SW-1] && !sm[SW-1];
    assign acc_nar[gk*LW +: LW] = p_frac ? ov[SW-1:LW] : ov[LW-1:0];
    assign lp_nar[gk*LW +: LW]  = p_frac ? pp[SW-1:LW] : pp[LW-1:0];
  end

  logic [3:0] hi_nib;
  assign hi_nib = ovf_q[{p_pair, 1'b1, 2'b00} +: 4];

  always_comb begin
    acc_d = acc_q;
    ovf_d = ovf_q;
    res_d = res_q;
    vld_d = out_op;
    if (!p_quad) begin
      if (p_op == OP_MUL)
        res_d = p_wide ? {{(RW-DW){1'b0}}, p_sp}
                       : {{(RW-SW){1'b0}}, (p_frac ? p_sp[DW-1:SW] : p_sp[SW-1:0])};
      else if (p_op == OP_XFR || p_op == OP_XMAC)
        res_d = p_wide ? {{(RW-DW){1'b0}}, pv}
                       : {{(RW-SW){1'b0}}, (p_frac ? pv[DW-1:SW] : pv[SW-1:0])};
      if (mac_op || new_op || clr_op) begin
        if (p_pair) acc_d[RW-1:DW] = mac_op ? psum : (new_op ? p_sp : '0);
        else        acc_d[DW-1:0]  = mac_op ? psum : (new_op ? p_sp : '0);
        if (mac_op) begin
          ovf_d[{p_pair, 1'b1, 2'b00} +: 4] =
            hi_nib | {(p_pos || p_neg) && (hi_nib[0] || hi_nib[1]), p_ssat, p_neg, p_pos};
        end else begin
          ovf_d[{p_pair, 1'b1, 2'b00} +: 4] = {1'b0, new_op && p_ssat, 2'b00};
          ovf_d[{p_pair, 1'b0, 2'b00} +: 4] = 4'b0000;
        end
      end
    end else begin
      if (p_op == OP_MUL)
        res_d = p_wide ? p_lp : {{(RW-DW){1'b0}}, lp_nar};
      else if (p_op == OP_XFR || p_op == OP_XMAC)
        res_d = p_wide ? acc_q : {{(RW-DW){1'b0}}, acc_nar};
      if (mac_op || new_op || clr_op) begin
        for (int k = 0; k < NL; k++) begin
          acc_d[k*SW +: SW] = mac_op ? l_sum[k*SW +: SW] : (new_op ? p_lp[k*SW +: SW] : '0);
          if (mac_op)
            ovf_d[k*4 +: 4] = ovf_q[k*4 +: 4] |
              {(l_pos[k] || l_neg[k]) && (ovf_q[k*4] || ovf_q[k*4+1]), p_lsat[k], l_neg[k], l_pos[k]};
          else
            ovf_d[k*4 +: 4] = {1'b0, new_op && p_lsat[k], 2'b00};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; ovf_q <= '0; res_q <= '0; vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d; ovf_q <= ovf_d; res_q <= res_d; vld_q <= vld_d;
    end
  end

  assign acc_o     = acc_q;
  assign ovf_o     = ovf_q;
  assign res_o     = res_q;
  assign res_vld_o = vld_q;

  // R2
  vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> ($past(p_op) == OP_MUL || $past(p_op) == OP_XFR || $past(p_op) == OP_XMAC));

  // R11
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_op == OP_MAC |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

  for (genvar gc = 0; gc < NL; gc++) begin : g_chk
    // R11
    repeat_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o[4*gc+3] |-> (ovf_o[4*gc] || ovf_o[4*gc+1]));
    // R5
    frac_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_op == OP_MUL && p_quad && p_wide && p_frac) |=> res_o[gc*SW +: SW] != SMIN);
  end

  // R9
  xfr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_XFR && p_quad) |=> (acc_o == '0 && ovf_o == '0));

  // R10
  xmac_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_XMAC && !p_quad && p_wide) |=>
      res_o[DW-1:0] == $past(p_pair ? acc_o[RW-1:DW] : acc_o[DW-1:0]));

  // R12
  mul_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_op == OP_MUL |=> ($stable(acc_o) && $stable(ovf_o)));

  // R13
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op != OP_MUL && p_op != OP_XFR && p_op != OP_XMAC) |=> $stable(res_o));
endmodule

// File: tb/simd_mac_tb.sv
module simd_mac_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_i = '0;
  logic quad_i = 1'b0, wide_i = 1'b0, frac_i = 1'b0, pair_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [127:0] res_o, acc_o;
  logic res_vld_o;
  logic [15:0] ovf_o;

  simd_mac u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .quad_i(quad_i), .wide_i(wide_i),
    .frac_i(frac_i), .pair_i(pair_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .res_vld_o(res_vld_o), .acc_o(acc_o), .ovf_o(ovf_o)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [127:0] m_acc = '0, m_res = '0;
  logic [15:0]  m_ovf = '0;
  logic         m_vld = 1'b0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sprod(input logic [31:0] a, input logic [31:0] b,
                                        input logic fr, output logic sat);
    longint x;
    x = longint'($signed(a)) * longint'($signed(b));
    sat = fr && a == 32'h8000_0000 && b == 32'h8000_0000;
    if (sat) return 64'h7FFF_FFFF_FFFF_FFFF;
    return fr ? x * 2 : x;
  endfunction

  function automatic logic [31:0] lprod(input logic [15:0] a, input logic [15:0] b,
                                        input logic fr, output logic sat);
    longint x;
    x = longint'($signed(a)) * longint'($signed(b));
    sat = fr && a == 16'h8000 && b == 16'h8000;
    if (sat) return 32'h7FFF_FFFF;
    if (fr) x = x * 2;
    return x[31:0];
  endfunction

  task automatic model(input logic [2:0] op, input logic q, input logic w, input logic f,
                       input logic p, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] sp, old;
    logic ss, t;
    logic [127:0] lp;
    logic [3:0] ls, nb;
    logic signed [64:0] e;
    longint le;
    int hi, lo;
    sp = sprod(a[31:0], b[31:0], f, ss);
    for (int k = 0; k < 4; k++) begin
      lp[k*32 +: 32] = lprod(a[k*16 +: 16], b[k*16 +: 16], f, t);
      ls[k] = t;
    end
    m_vld = (op == 1 || op == 4 || op == 5);
    if (!q) begin
      old = p ? m_acc[127:64] : m_acc[63:0];
      hi = p ? 3 : 1;
      lo = p ? 2 : 0;
      if (op == 1) m_res = w ? {64'b0, sp} : {96'b0, (f ? sp[63:32] : sp[31:0])};
      if (op == 4 || op == 5) m_res = w ? {64'b0, old} : {96'b0, (f ? old[63:32] : old[31:0])};
      if (op >= 2 && op <= 6) begin
        if (op == 2) begin
          e = $signed({old[63], old}) + $signed({sp[63], sp});
          nb = m_ovf[hi*4 +: 4];
          t = (e[64] != e[63]);
          m_ovf[hi*4 +: 4] = nb | {t && (nb[0] || nb[1]), ss, t && e[64], t && !e[64]};
          old = e[63:0];
        end else begin
          old = (op == 3 || op == 5) ? sp : 64'b0;
          m_ovf[hi*4 +: 4] = {1'b0, (op == 3 || op == 5) && ss, 2'b00};
          m_ovf[lo*4 +: 4] = 4'b0;
        end
        if (p) m_acc[127:64] = old; else m_acc[63:0] = old;
      end
    end else begin
      if (op == 1) begin
        if (w) m_res = lp;
        else for (int k = 0; k < 4; k++) m_res[k*16 +: 16] = f ? lp[k*32+16 +: 16] : lp[k*32 +: 16];
        if (!w) m_res[127:64] = '0;
      end
      if (op == 4 || op == 5) begin
        if (w) m_res = m_acc;
        else begin
          m_res = '0;
          for (int k = 0; k < 4; k++) m_res[k*16 +: 16] = f ? m_acc[k*32+16 +: 16] : m_acc[k*32 +: 16];
        end
      end
      if (op >= 2 && op <= 6) begin
        for (int k = 0; k < 4; k++) begin
          if (op == 2) begin
            le = longint'($signed(m_acc[k*32 +: 32])) + longint'($signed(lp[k*32 +: 32]));
            nb = m_ovf[k*4 +: 4];
            t = (le > 64'sd2147483647) || (le < -64'sd2147483648);
            m_ovf[k*4 +: 4] = nb | {t && (nb[0] || nb[1]), ls[k], le < -64'sd2147483648, le > 64'sd2147483647};
            m_acc[k*32 +: 32] = le[31:0];
          end else begin
            m_acc[k*32 +: 32] = (op == 3 || op == 5) ? lp[k*32 +: 32] : 32'b0;
            m_ovf[k*4 +: 4] = {1'b0, (op == 3 || op == 5) && ls[k], 2'b00};
          end
        end
      end
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic q, input logic w, input logic f,
                       input logic p, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_i = op; quad_i = q; wide_i = w; frac_i = f; pair_i = p; a_i = a; b_i = b;
    model(op, q, w, f, p, a, b);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " res_vld_o"}, {127'b0, res_vld_o}, {127'b0, m_vld});
    chk({tag, " res_o"}, res_o, m_res);
    chk({tag, " acc_o"}, acc_o, m_acc);
    chk({tag, " ovf_o"}, {112'b0, ovf_o}, {112'b0, m_ovf});
  endtask

  task automatic do_op(input logic [2:0] op, input logic q, input logic w, input logic f,
                       input logic p, input logic [63:0] a, input logic [63:0] b, input string tag);
    drive(op, q, w, f, p, a, b);
    @(posedge clk);
    @(negedge clk);
    op_i = 3'd0;
    @(posedge clk);
    #2;
    check_all(tag);
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    op_i = 3'd0;
    @(posedge clk);
    @(posedge clk);
    #2;
    m_vld = 1'b0;
    check_all(tag);
  endtask

  logic [31:0] v32 [8];
  logic [15:0] v16 [8];

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    v32 = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h2, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678, 32'hFFFF_F000};
    v16 = '{16'h0, 16'h1, 16'hFFFF, 16'h2, 16'h8000, 16'h7FFF, 16'h1234, 16'hF001};
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R3 / R5: single-mode products, garbage in upper operand bits
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 4; m++)
          do_op(3'd1, 1'b0, m[0], m[1], 1'b0, {32'hDEAD_BEEF, v32[i]}, {32'h0BAD_F00D, v32[j]},
                "R3 R5 R12 single MUL");

    // R4 / R5: quad products
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 4; m++) begin
          logic [63:0] a, b;
          for (int k = 0; k < 4; k++) begin
            a[k*16 +: 16] = v16[(i + k) % 8];
            b[k*16 +: 16] = v16[(j + 3*k) % 8];
          end
          do_op(3'd1, 1'b1, m[0], m[1], 1'b0, a, b, "R4 R5 quad MUL");
        end

    // R6 / R11: pair 0 wraps upward twice
    do_op(3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 64'h7FFF_FFFF, 64'h7FFF_FFFF, "R6 SET pair0");
    for (int n = 0; n < 4; n++)
      do_op(3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 64'h7FFF_FFFF, 64'h7FFF_FFFF, "R6 R11 MAC pair0 wrap");
    // R5 / R11: pair 1 receives a clamped product
    do_op(3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 64'h8000_0000, 64'h8000_0000, "R6 SET pair1");
    do_op(3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 64'h8000_0000, 64'h8000_0000, "R5 R11 MAC clamp pair1");
    do_op(3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 64'hFFFF_FFFF, 64'h0000_0003, "R6 MAC pair1 negative");
    // R9: narrow integer transfer of pair 1, then fractional narrow of pair 0
    do_op(3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0, 64'h0, "R9 XFR pair1 int narrow");
    do_op(3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, "R9 XFR pair0 frac narrow");

    // R7 / R11: quad lanes wrap downward
    do_op(3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 64'h8000_8000_8000_8000, 64'h7FFF_7FFF_7FFF_7FFF, "R7 SET quad");
    do_op(3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 64'h8000_8000_8000_8000, 64'h7FFF_7FFF_7FFF_7FFF, "R7 R11 MAC quad wrap");
    do_op(3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 64'h8000_8000_8000_8000, 64'h7FFF_8000_7FFF_8000, "R7 R11 MAC quad repeat");
    do_op(3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 64'h1234_FFFF_0002_8000, 64'h0003_0005_7FFF_8000, "R7 MAC quad int");
    // R10: transfer old quad contents and restart
    do_op(3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 64'h0001_0002_0003_8000, 64'h0004_0005_0006_8000, "R10 XMAC quad narrow");
    do_op(3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0007_0008_0009_000A, 64'hFFFF_0002_0003_0004, "R10 XMAC quad wide");
    // R12 / R13: clear quad, result port holds
    do_op(3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R12 R13 CLR quad");
    do_op(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h5, 64'h6, "R13 idle");

    // R8 / R10: back-to-back single accumulation ending in transfer-and-restart
    drive(3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 64'h0001_0000, 64'h0001_0000);
    drive(3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 64'hFFFF_FFFF, 64'h7FFF_FFFF);
    drive(3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1234_5678, 64'h8765_4321);
    drive(3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0003, 64'h0000_0005);
    drive(3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 64'h0000_0002, 64'h0000_0009);
    drain("R8 R10 back-to-back single");

    // R8: back-to-back quad accumulation
    drive(3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF);
    for (int n = 0; n < 3; n++)
      drive(3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 64'h7FFF_7FFF_8000_8000, 64'h7FFF_7FFF_8000_8000);
    drive(3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0);
    drive(3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0003_0002_0001_FFFF, 64'h0004_0004_0004_0004);
    drain("R8 R9 back-to-back quad");

    // R9 / R12: clear pair 1 without touching pair 0 or res_o
    do_op(3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0011, 64'h0000_0022, "R6 SET pair0 again");
    do_op(3'd6, 1'b0, 1'b1, 1'b0, 1'b1, 64'h0, 64'h0, "R12 CLR pair1");
    do_op(3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0, "R9 XFR pair0 wide");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule